// File: doc/BRIEF.md
# Rotating-Top Extended Register Stack with Packed Alias View

This block holds eight 80-bit registers that two kinds of client reach in different ways. A floating-point client treats them as a stack. Its register numbers count downward from a 3-bit top pointer. Push, pop and write-to-top move or replace entries, and two relative read ports return any depth of the stack together with an empty indication. A per-entry valid bit detects a push onto an occupied slot (overflow) and a pop or enabled read of an empty slot (underflow). Each condition appears as a one-cycle flag.

A packed-integer client sees the same storage as eight fixed 64-bit registers. A packed write fills the low 64 bits of the addressed entry and forces its upper 16 bits high. It also returns the stack to a known shape: the top pointer goes to zero and every entry is marked valid. A packed read returns the low 64 bits of the addressed entry. A lane extractor selects one 64-, 32-, 16- or 8-bit lane from that word and zero-extends it.

Top module: `fpr_stack_regfile`

## Requirements
- R1: After reset the top pointer is 0, every entry is empty, every stored value is zero, and both flags are low.
- R2: Relative read index i returns the physical entry (top + i) mod 8 in the same cycle, and its empty output is high exactly when that entry is not valid.
- R3: An accepted push decrements the top pointer modulo 8 (0 wraps to 7), writes the push data into the new top and marks it valid. Older entries then appear one relative index deeper.
- R4: A push whose target slot (top - 1) mod 8 is already valid changes nothing, and raises overflow for one cycle after that edge.
- R5: pop_data always shows relative entry 0. An accepted pop marks that entry empty and increments the top pointer modulo 8.
- R6: A pop of an empty top changes nothing, and raises underflow for one cycle after that edge. An enabled relative read of an empty entry also raises underflow for one cycle.
- R7: Write-to-top replaces the data of relative entry 0, marks it valid and leaves the top pointer unchanged.
- R8: A packed write to absolute index k stores the 64 data bits in bits 63:0 of physical entry k and sets bits 79:64 to 16'hFFFF.
- R9: A packed write sets the top pointer to 0 and marks all eight entries valid.
- R10: A packed read of absolute index k returns bits 63:0 of physical entry k, whatever the top pointer is.
- R11: The lane output takes the packed read word and splits it by lane size code: 0 gives the whole 64-bit word, 1 gives 32-bit lanes, 2 gives 16-bit lanes, 3 gives 8-bit lanes. Lane n starts at bit n times the lane width. The lane index is taken modulo the lane count, and the result is zero-extended.
- R12: Priority in one cycle runs from packed write, to push, to pop, to write-to-top. A request that loses has no effect on storage, pointer or flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_en | input | 1 | Push request |
| push_data | input | 80 | Data for the new top |
| pop_en | input | 1 | Pop request |
| pop_data | output | 80 | Current top entry |
| wtop_en | input | 1 | Write-to-top request |
| wtop_data | input | 80 | Data for the top entry |
| rda_en | input | 1 | Read port A underflow check enable |
| rda_idx | input | 3 | Read port A relative index |
| rda_data | output | 80 | Read port A data |
| rda_empty | output | 1 | Read port A entry empty |
| rdb_en | input | 1 | Read port B underflow check enable |
| rdb_idx | input | 3 | Read port B relative index |
| rdb_data | output | 80 | Read port B data |
| rdb_empty | output | 1 | Read port B entry empty |
| pk_wr_en | input | 1 | Packed write request |
| pk_wr_idx | input | 3 | Packed write absolute index |
| pk_wr_data | input | 64 | Packed write data |
| pk_rd_idx | input | 3 | Packed read absolute index |
| pk_rd_data | output | 64 | Packed read data |
| pk_lane_sz | input | 2 | Lane size code (0:64, 1:32, 2:16, 3:8) |
| pk_lane_idx | input | 3 | Lane number |
| pk_lane_data | output | 64 | Selected lane, zero-extended |
| top_ptr | output | 3 | Current top pointer |
| overflow | output | 1 | One-cycle stack overflow flag |
| underflow | output | 1 | One-cycle stack underflow flag |

## Verification
The two functions that can land in the same cycle are a packed write and a stack operation. Two stack operations can also collide, for example a push with a pop, or a pop with write-to-top. The bench raises both requests on the same edge. It then judges the result at the ports: the top pointer, the data at the affected relative depths and the absence of any flag must match only the winning request. Each test reads back the entry that the losing request would have written, which shows that the losing request left no mark.

// File: rtl/fpr_pkg.sv
// Package: shared sizes and the lane size encoding for the register stack.
// Assumes the entry count is a power of two so pointer arithmetic wraps naturally.
package fpr_pkg;
    localparam int FPR_ENTRIES = 8;
    localparam int FPR_EXT_W   = 80;
    localparam int FPR_PK_W    = 64;

    typedef enum logic [1:0] {
        LANE_64 = 2'd0,
        LANE_32 = 2'd1,
        LANE_16 = 2'd2,
        LANE_8  = 2'd3
    } lane_sz_e;
endpackage

// File: rtl/fpr_tos_ctrl.sv
// Module: top pointer, valid bits, request arbitration and stack flags.
// Assumes ENTRIES is a power of two. Priority: packed write, push, pop, write-to-top.
module fpr_tos_ctrl #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_req,
    input  logic               pop_req,
    input  logic               wtop_req,
    input  logic               pk_wr_req,
    input  logic               rd_empty_hit,
    output logic [IDX_W-1:0]   top_q,
    output logic [ENTRIES-1:0] valid_q,
    output logic               st_we,
    output logic [IDX_W-1:0]   st_widx,
    output logic               st_from_push,
    output logic               ovf_q,
    output logic               unf_q
);
    logic [IDX_W-1:0] top_dec;
    logic [IDX_W-1:0] top_inc;
    logic push_sel, pop_sel, wtop_sel;
    logic push_ok, pop_ok;

    // Arbitrate the requests and decide which stack operation is accepted.
    always_comb begin
        top_dec  = top_q - 1'b1;
        top_inc  = top_q + 1'b1;
        push_sel = push_req && !pk_wr_req;
        pop_sel  = pop_req && !push_req && !pk_wr_req;
        wtop_sel = wtop_req && !pop_req && !push_req && !pk_wr_req;
        push_ok  = push_sel && !valid_q[top_dec];
        pop_ok   = pop_sel && valid_q[top_q];
    end

    // Select the storage write for a stack-side update.
    always_comb begin
        st_we        = push_ok || wtop_sel;
        st_from_push = push_ok;
        st_widx      = push_ok ? top_dec : top_q;
    end

    // Update the pointer, the valid bits and the one-cycle flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q   <= '0;
            valid_q <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            ovf_q <= push_sel && valid_q[top_dec];
            unf_q <= (pop_sel && !valid_q[top_q]) || rd_empty_hit;
            if (pk_wr_req) begin
                top_q   <= '0;
                valid_q <= '1;
            end else if (push_ok) begin
                top_q            <= top_dec;
                valid_q[top_dec] <= 1'b1;
            end else if (pop_ok) begin
                top_q          <= top_inc;
                valid_q[top_q] <= 1'b0;
            end else if (wtop_sel) begin
                valid_q[top_q] <= 1'b1;
            end
        end
    end

    // R3: an accepted push moves the pointer down by one.
    p_push_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pk_wr_req && !valid_q[IDX_W'(top_q - 1'b1)])
        |=> (top_q == IDX_W'($past(top_q) - 1'b1)));

    // R4: a push onto a valid slot flags overflow and keeps the pointer.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pk_wr_req && valid_q[IDX_W'(top_q - 1'b1)])
        |=> (ovf_q && $stable(top_q)));

    // R5: an accepted pop moves the pointer up by one.
    p_pop_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !pk_wr_req && valid_q[top_q])
        |=> (top_q == IDX_W'($past(top_q) + 1'b1)));

    // R6: a pop of an empty top flags underflow and keeps the pointer.
    p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !pk_wr_req && !valid_q[top_q])
        |=> (unf_q && $stable(top_q)));

    // R9: a packed write resets the pointer and fills the valid bits.
    p_pk_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pk_wr_req |=> (top_q == '0 && (&valid_q)));
endmodule

// File: rtl/fpr_storage.sv
// Module: eight wide entries with one stack-side write and one packed write.
// Assumes the controller never requests both writes in the same cycle.
// The packed write is checked first regardless.
module fpr_storage #(
    parameter int ENTRIES = 8,
    parameter int EXT_W   = 80,
    parameter int PK_W    = 64,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = EXT_W - PK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_we,
    input  logic [IDX_W-1:0] st_widx,
    input  logic [EXT_W-1:0] st_wdata,
    input  logic             pk_we,
    input  logic [IDX_W-1:0] pk_widx,
    input  logic [PK_W-1:0]  pk_wdata,
    output logic [EXT_W-1:0] ent_q [ENTRIES]
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [EXT_W-1:0] q;
        logic             pk_hit;
        logic             st_hit;

        // Decode whether this entry is addressed by either write.
        always_comb begin
            pk_hit = pk_we && (pk_widx == IDX_W'(g));
            st_hit = st_we && (st_widx == IDX_W'(g));
        end

        // Hold one entry; a packed write forces the tag bits high.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (pk_hit) begin
                q <= {{TAG_W{1'b1}}, pk_wdata};
            end else if (st_hit) begin
                q <= st_wdata;
            end
        end

        assign ent_q[g] = q;

        // R8: a packed write leaves all-ones tag bits and the given low word.
        p_pk_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (pk_we && pk_widx == IDX_W'(g))
            |=> (ent_q[g][EXT_W-1:PK_W] == {TAG_W{1'b1}}
                 && ent_q[g][PK_W-1:0] == $past(pk_wdata)));

        // R12: an entry addressed by no write keeps its value.
        p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (!(pk_we && pk_widx == IDX_W'(g)) && !(st_we && st_widx == IDX_W'(g)))
            |=> $stable(ent_q[g]));
    end
endmodule

// File: rtl/fpr_lane_extract.sv
// Module: selects one lane of a packed word by size code and zero-extends it.
// Assumes PK_W is a power of two of at least 8. Size code s gives lanes of PK_W >> s bits.
module fpr_lane_extract #(
    parameter int PK_W    = 64,
    localparam int LIDX_W = $clog2(PK_W / 8),
    localparam int N_SZ   = LIDX_W + 1,
    localparam int SZ_W   = $clog2(N_SZ)
) (
    input  logic [PK_W-1:0]   word,
    input  logic [SZ_W-1:0]   size,
    input  logic [LIDX_W-1:0] lane,
    output logic [PK_W-1:0]   res
);
    logic [PK_W-1:0] cand [N_SZ];

    for (genvar s = 0; s < N_SZ; s++) begin : g_sz
        localparam int LW = PK_W >> s;
        localparam int NL = 1 << s;
        logic [PK_W-1:0] c;

        // Build the zero-extended lane for this size; lane number wraps modulo NL.
        always_comb begin
            c = '0;
            for (int k = 0; k < NL; k++) begin
                if ((int'(lane) % NL) == k) begin
                    c[LW-1:0] = word[k*LW +: LW];
                end
            end
        end

        assign cand[s] = c;
    end

    // Choose the candidate of the requested size.
    always_comb begin
        res = '0;
        for (int s = 0; s < N_SZ; s++) begin
            if (int'(size) == s) begin
                res = cand[s];
            end
        end
    end
endmodule

// File: rtl/fpr_stack_regfile.sv
// Module: stack-addressed extended register file with a packed 64-bit alias view.
// Assumes ENTRIES is a power of two so (top + i) wraps in the pointer width.
// Reads are combinational; flags appear one cycle after the request.
module fpr_stack_regfile #(
    parameter int ENTRIES = fpr_pkg::FPR_ENTRIES,
    parameter int EXT_W   = fpr_pkg::FPR_EXT_W,
    parameter int PK_W    = fpr_pkg::FPR_PK_W,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int LIDX_W = $clog2(PK_W / 8),
    localparam int SZ_W   = $clog2(LIDX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [EXT_W-1:0]  push_data,
    input  logic              pop_en,
    output logic [EXT_W-1:0]  pop_data,
    input  logic              wtop_en,
    input  logic [EXT_W-1:0]  wtop_data,
    input  logic              rda_en,
    input  logic [IDX_W-1:0]  rda_idx,
    output logic [EXT_W-1:0]  rda_data,
    output logic              rda_empty,
    input  logic              rdb_en,
    input  logic [IDX_W-1:0]  rdb_idx,
    output logic [EXT_W-1:0]  rdb_data,
    output logic              rdb_empty,
    input  logic              pk_wr_en,
    input  logic [IDX_W-1:0]  pk_wr_idx,
    input  logic [PK_W-1:0]   pk_wr_data,
    input  logic [IDX_W-1:0]  pk_rd_idx,
    output logic [PK_W-1:0]   pk_rd_data,
    input  logic [SZ_W-1:0]   pk_lane_sz,
    input  logic [LIDX_W-1:0] pk_lane_idx,
    output logic [PK_W-1:0]   pk_lane_data,
    output logic [IDX_W-1:0]  top_ptr,
    output logic              overflow,
    output logic              underflow
);
    logic [IDX_W-1:0]   top_q;
    logic [ENTRIES-1:0] valid_q;
    logic               st_we;
    logic [IDX_W-1:0]   st_widx;
    logic               st_from_push;
    logic [EXT_W-1:0]   st_wdata;
    logic [EXT_W-1:0]   ent_q [ENTRIES];
    logic [IDX_W-1:0]   phys_a;
    logic [IDX_W-1:0]   phys_b;
    logic               rd_empty_hit;

    // Map relative read indices onto physical entries and test emptiness.
    always_comb begin
        phys_a       = top_q + rda_idx;
        phys_b       = top_q + rdb_idx;
        rda_data     = ent_q[phys_a];
        rdb_data     = ent_q[phys_b];
        rda_empty    = !valid_q[phys_a];
        rdb_empty    = !valid_q[phys_b];
        pop_data     = ent_q[top_q];
        rd_empty_hit = (rda_en && !valid_q[phys_a]) || (rdb_en && !valid_q[phys_b]);
        st_wdata     = st_from_push ? push_data : wtop_data;
        pk_rd_data   = ent_q[pk_rd_idx][PK_W-1:0];
        top_ptr      = top_q;
    end

    fpr_tos_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_req     (push_en),
        .pop_req      (pop_en),
        .wtop_req     (wtop_en),
        .pk_wr_req    (pk_wr_en),
        .rd_empty_hit (rd_empty_hit),
        .top_q        (top_q),
        .valid_q      (valid_q),
        .st_we        (st_we),
        .st_widx      (st_widx),
        .st_from_push (st_from_push),
        .ovf_q        (overflow),
        .unf_q        (underflow)
    );

    fpr_storage #(.ENTRIES(ENTRIES), .EXT_W(EXT_W), .PK_W(PK_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_we    (st_we),
        .st_widx  (st_widx),
        .st_wdata (st_wdata),
        .pk_we    (pk_wr_en),
        .pk_widx  (pk_wr_idx),
        .pk_wdata (pk_wr_data),
        .ent_q    (ent_q)
    );

    fpr_lane_extract #(.PK_W(PK_W)) lane_i (
        .word (pk_rd_data),
        .size (pk_lane_sz),
        .lane (pk_lane_idx),
        .res  (pk_lane_data)
    );

    // R11: byte lanes leave every bit above the lowest byte clear.
    p_byte_lane_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_lane_sz == SZ_W'(fpr_pkg::LANE_8)) |-> (pk_lane_data[PK_W-1:8] == '0));

    // R6: an enabled read of an empty entry raises underflow next cycle.
    p_rd_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rda_en && rda_empty) |=> underflow);
endmodule

// File: tb/fpr_stack_regfile_tb.sv
`timescale 1ns/1ps
module fpr_stack_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_en, pop_en, wtop_en, rda_en, rdb_en, pk_wr_en;
    logic [79:0] push_data, wtop_data, pop_data, rda_data, rdb_data;
    logic [2:0]  rda_idx, rdb_idx, pk_wr_idx, pk_rd_idx, pk_lane_idx, top_ptr;
    logic [63:0] pk_wr_data, pk_rd_data, pk_lane_data;
    logic [1:0]  pk_lane_sz;
    logic        rda_empty, rdb_empty, overflow, underflow;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [63:0] XV = 64'hDEAD_BEEF_0123_4567;
    localparam logic [63:0] YV = 64'h0BAD_F00D_CAFE_1234;

    always #2.5 clk = ~clk;

    fpr_stack_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_en), .push_data(push_data),
        .pop_en(pop_en), .pop_data(pop_data),
        .wtop_en(wtop_en), .wtop_data(wtop_data),
        .rda_en(rda_en), .rda_idx(rda_idx), .rda_data(rda_data), .rda_empty(rda_empty),
        .rdb_en(rdb_en), .rdb_idx(rdb_idx), .rdb_data(rdb_data), .rdb_empty(rdb_empty),
        .pk_wr_en(pk_wr_en), .pk_wr_idx(pk_wr_idx), .pk_wr_data(pk_wr_data),
        .pk_rd_idx(pk_rd_idx), .pk_rd_data(pk_rd_data),
        .pk_lane_sz(pk_lane_sz), .pk_lane_idx(pk_lane_idx), .pk_lane_data(pk_lane_data),
        .top_ptr(top_ptr), .overflow(overflow), .underflow(underflow)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        push_en = 0; pop_en = 0; wtop_en = 0; rda_en = 0; rdb_en = 0; pk_wr_en = 0;
    endtask

    // Read relative index i on port A and return data and empty.
    task automatic peek(input logic [2:0] i, output logic [79:0] d, output logic e);
        rda_idx = i;
        #0.1;
        d = rda_data;
        e = rda_empty;
    endtask

    function automatic logic [79:0] vk(input int k);
        return 80'h1000 + 80'(k);
    endfunction

    task automatic t_reset();
        logic [79:0] d; logic e;
        chk("R1 top", 80'(top_ptr), 80'd0);
        peek(3'd0, d, e);
        chk("R1 empty", 80'(e), 80'd1);
        chk("R1 data", d, 80'd0);
        chk("R1 ovf", 80'(overflow), 80'd0);
        chk("R1 unf", 80'(underflow), 80'd0);
    endtask

    task automatic t_push();
        logic [79:0] d; logic e;
        push_en = 1; push_data = 80'hA; tick();
        chk("R3 wrap top", 80'(top_ptr), 80'd7);
        push_data = 80'hB; tick();
        push_data = 80'hC; tick();
        idle();
        chk("R3 top", 80'(top_ptr), 80'd5);
        peek(3'd0, d, e); chk("R3 st0", d, 80'hC);
        peek(3'd1, d, e); chk("R2 st1", d, 80'hB);
        peek(3'd2, d, e); chk("R2 st2", d, 80'hA);
        peek(3'd3, d, e); chk("R2 st3 empty", 80'(e), 80'd1);
        rdb_idx = 3'd2; #0.1;
        chk("R2 port b", rdb_data, 80'hA);
    endtask

    task automatic t_wtop();
        logic [79:0] d; logic e;
        wtop_en = 1; wtop_data = 80'hD; tick(); idle();
        chk("R7 top", 80'(top_ptr), 80'd5);
        peek(3'd0, d, e); chk("R7 st0", d, 80'hD);
        peek(3'd1, d, e); chk("R7 st1", d, 80'hB);
    endtask

    task automatic t_pop();
        logic [79:0] d; logic e;
        pop_en = 1; #0.1;
        chk("R5 pop data", pop_data, 80'hD);
        tick(); idle();
        chk("R5 top", 80'(top_ptr), 80'd6);
        peek(3'd0, d, e); chk("R5 st0", d, 80'hB);
        peek(3'd7, d, e); chk("R5 freed empty", 80'(e), 80'd1);
    endtask

    task automatic t_underflow();
        rda_en = 1; rda_idx = 3'd4; tick(); idle();
        chk("R6 read unf", 80'(underflow), 80'd1);
        tick();
        chk("R6 unf clears", 80'(underflow), 80'd0);
        pop_en = 1; tick(); tick(); idle();
        chk("R6 drained top", 80'(top_ptr), 80'd0);
        pop_en = 1; tick(); idle();
        chk("R6 pop unf", 80'(underflow), 80'd1);
        chk("R6 pop top kept", 80'(top_ptr), 80'd0);
    endtask

    task automatic t_overflow();
        logic [79:0] d; logic e;
        for (int k = 1; k <= 8; k++) begin
            push_en = 1; push_data = vk(k); tick();
        end
        idle();
        chk("R3 full top", 80'(top_ptr), 80'd0);
        peek(3'd0, d, e); chk("R3 full st0", d, vk(8));
        peek(3'd7, d, e); chk("R3 full st7", d, vk(1));
        push_en = 1; push_data = 80'hEEEE; tick(); idle();
        chk("R4 ovf", 80'(overflow), 80'd1);
        chk("R4 top kept", 80'(top_ptr), 80'd0);
        peek(3'd0, d, e); chk("R4 st0 kept", d, vk(8));
        tick();
        chk("R4 ovf clears", 80'(overflow), 80'd0);
    endtask

    task automatic t_packed();
        logic [79:0] d; logic e;
        pop_en = 1; tick(); tick(); idle();
        chk("R5 two pops", 80'(top_ptr), 80'd2);
        pk_wr_en = 1; pk_wr_idx = 3'd3; pk_wr_data = XV; tick(); idle();
        chk("R9 top", 80'(top_ptr), 80'd0);
        peek(3'd0, d, e); chk("R9 st0 valid", 80'(e), 80'd0);
        peek(3'd1, d, e); chk("R9 st1 valid", 80'(e), 80'd0);
        peek(3'd3, d, e); chk("R8 tag", d, {16'hFFFF, XV});
        pk_rd_idx = 3'd3; #0.1;
        chk("R10 rd", 80'(pk_rd_data), 80'(XV));
        pk_rd_idx = 3'd5; #0.1;
        chk("R10 rd other", 80'(pk_rd_data), 80'(vk(3)));
        pop_en = 1; tick(); idle();
        pk_rd_idx = 3'd3; #0.1;
        chk("R10 rd after pop", 80'(pk_rd_data), 80'(XV));
        peek(3'd2, d, e); chk("R2 alias", d, {16'hFFFF, XV});
    endtask

    task automatic t_lanes();
        logic [63:0] exp [9];
        logic [1:0]  sz  [9];
        logic [2:0]  ln  [9];
        sz[0] = 2'd0; ln[0] = 3'd5; exp[0] = XV;
        sz[1] = 2'd1; ln[1] = 3'd1; exp[1] = 64'hDEADBEEF;
        sz[2] = 2'd1; ln[2] = 3'd0; exp[2] = 64'h01234567;
        sz[3] = 2'd2; ln[3] = 3'd2; exp[3] = 64'hBEEF;
        sz[4] = 2'd2; ln[4] = 3'd3; exp[4] = 64'hDEAD;
        sz[5] = 2'd3; ln[5] = 3'd7; exp[5] = 64'hDE;
        sz[6] = 2'd3; ln[6] = 3'd0; exp[6] = 64'h67;
        sz[7] = 2'd1; ln[7] = 3'd3; exp[7] = 64'hDEADBEEF;
        sz[8] = 2'd2; ln[8] = 3'd5; exp[8] = 64'h0123;
        pk_rd_idx = 3'd3;
        for (int n = 0; n < 9; n++) begin
            pk_lane_sz = sz[n]; pk_lane_idx = ln[n]; #0.1;
            chk("R11 lane", 80'(pk_lane_data), 80'(exp[n]));
        end
    endtask

    task automatic t_priority();
        logic [79:0] d; logic e;
        push_en = 1; push_data = 80'h5555;
        pk_wr_en = 1; pk_wr_idx = 3'd6; pk_wr_data = YV; tick(); idle();
        chk("R12 pk over push top", 80'(top_ptr), 80'd0);
        chk("R12 no ovf", 80'(overflow), 80'd0);
        peek(3'd0, d, e); chk("R12 push dropped", d, vk(8));
        peek(3'd6, d, e); chk("R12 pk wrote", d, {16'hFFFF, YV});
        pop_en = 1; tick(); idle();
        push_en = 1; push_data = 80'h7777; pop_en = 1; tick(); idle();
        chk("R12 push over pop top", 80'(top_ptr), 80'd0);
        peek(3'd0, d, e); chk("R12 push won", d, 80'h7777);
        chk("R12 push valid", 80'(e), 80'd0);
        pop_en = 1; wtop_en = 1; wtop_data = 80'h9999; tick(); idle();
        chk("R12 pop over wtop top", 80'(top_ptr), 80'd1);
        peek(3'd7, d, e); chk("R12 wtop dropped", d, 80'h7777);
        chk("R12 popped empty", 80'(e), 80'd1);
    endtask

    initial begin
        idle();
        rst_n = 0; push_data = '0; wtop_data = '0; rda_idx = '0; rdb_idx = '0;
        pk_wr_idx = '0; pk_wr_data = '0; pk_rd_idx = '0; pk_lane_sz = '0; pk_lane_idx = '0;
        tick(); tick(); tick();
        rst_n = 1;
        tick();
        t_reset();
        t_push();
        t_wtop();
        t_pop();
        t_underflow();
        t_overflow();
        t_packed();
        t_lanes();
        t_priority();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule